// File: doc/BRIEF.md
# Speculative Load Conflict Table

This block is a small, fully associative table that tells a processor whether a load it hoisted above earlier stores is still good. When a data-speculative load executes, the table records the load's destination register number, its byte address and its access size. Every store that later executes is compared against all live records at once. Any record whose byte range overlaps the store's byte range is killed.

When the program reaches the point where the load originally stood, a check request names the destination register. One cycle later the block answers. A hit means the speculative value may be kept. A miss means the caller must reload non-speculatively or branch to recovery code.

A clear input empties the whole table. Table updates are meant to be driven from the pipeline stage that follows execute. The block holds no pipeline control of its own.

Top module: `spec_ld_tbl`

## Requirements
- R1: After reset every entry is invalid and `chk_done_o` is low; a check issued right after reset returns a miss.
- R2: A check request in cycle N gives `chk_done_o` high for exactly cycle N+1, with `chk_hit_o` high only if a valid entry holds the named register; `chk_hit_o` is low whenever `chk_done_o` is low.
- R3: An insert records register, address and size; the size code s (0..3) means 2^s bytes starting at the address, and the entry is valid from the next cycle.
- R4: A store kills every valid entry whose byte range overlaps the store's range [addr, addr + 2^size), including partial overlaps at different start addresses; entries that merely touch the store's range at its edges survive.
- R5: Inserting a register that already has a valid entry overwrites that entry in place (new address and size), so a store to the old range no longer kills it and no other entry is consumed.
- R6: A new register takes the lowest-numbered free entry, and all 32 entries (parameter `ENTRIES`) can hold distinct registers at once.
- R7: When no entry is free, the new register replaces the entry at a round-robin pointer that starts at entry 0 after reset and advances by one (wrapping) only on such a replacement.
- R8: When an insert and a store occur in the same cycle, the store is applied after the insert: an overlapping store kills the new entry, a non-overlapping one leaves it valid.
- R9: `clear_i` invalidates every entry in the next cycle, and an insert in the same cycle as a clear is dropped.
- R10: A check sees the table as it was before the updates of its own cycle (an insert, a store or a clear in that cycle does not affect its result).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Invalidate all entries |
| ld_valid_i | input | 1 | Speculative-load insert request |
| ld_reg_i | input | REG_W | Destination register of the load |
| ld_addr_i | input | ADDR_W | Byte address of the load |
| ld_size_i | input | 2 | Load size code, 2^code bytes |
| st_valid_i | input | 1 | Store probe request |
| st_addr_i | input | ADDR_W | Byte address of the store |
| st_size_i | input | 2 | Store size code, 2^code bytes |
| chk_valid_i | input | 1 | Check request |
| chk_reg_i | input | REG_W | Register to check |
| chk_done_o | output | 1 | Check response valid, one cycle after request |
| chk_hit_o | output | 1 | Speculation succeeded (entry still valid) |

## Verification
Stores are probed at three kinds of address relative to a live entry. Some are inside its range at another start, some straddle one edge, and some sit exactly adjacent on either side. This separates a true overlap comparator from an equal-start match and from an off-by-one range end.

Inserts are tried against a repeated register, a free table and a full table. A repeated-register insert that is followed by a store to the old range shows overwrite against duplicate allocation. Filling all 32 entries, freeing one and then forcing victims shows lowest-free placement against round-robin order. It also shows that the pointer stays put on overwrites.

Same-cycle pairs separate the ordering rules. These are insert with store, insert with clear, and check with an insert or a store.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } sz_e;

  function automatic logic [3:0] span_bytes(sz_e sz);
    return 4'd1 << sz;
  endfunction

endpackage

// File: rtl/spec_ld_entry.sv
module spec_ld_entry
  import spec_ld_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int REG_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wr_reg_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  sz_e               wr_size_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  sz_e               st_size_i,
  input  logic [REG_W-1:0]  chk_reg_i,
  output logic              valid_o,
  output logic              ld_match_o,
  output logic              chk_match_o
);

  localparam int AW1 = ADDR_W + 1;

  logic              valid_q, valid_d;
  logic [REG_W-1:0]  reg_q;
  logic [ADDR_W-1:0] addr_q;
  sz_e               size_q;
  logic              kill_new, kill_old;

  function automatic logic ranges_meet(logic [ADDR_W-1:0] a, sz_e asz,
                                       logic [ADDR_W-1:0] b, sz_e bsz);
    logic [AW1-1:0] a_lo, a_hi, b_lo, b_hi;
    a_lo = {1'b0, a};
    b_lo = {1'b0, b};
    a_hi = a_lo + AW1'(span_bytes(asz));
    b_hi = b_lo + AW1'(span_bytes(bsz));
    return (a_lo < b_hi) && (b_lo < a_hi);
  endfunction

  assign kill_new = st_valid_i && ranges_meet(wr_addr_i, wr_size_i, st_addr_i, st_size_i);
  assign kill_old = st_valid_i && ranges_meet(addr_q, size_q, st_addr_i, st_size_i);

  // store applied after a same-cycle insert
  always_comb begin
    if (clear_i)       valid_d = 1'b0;
    else if (wr_i)     valid_d = !kill_new;
    else if (kill_old) valid_d = 1'b0;
    else               valid_d = valid_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q  <= '0;
      addr_q <= '0;
      size_q <= SZ_B;
    end else if (wr_i) begin
      reg_q  <= wr_reg_i;
      addr_q <= wr_addr_i;
      size_q <= wr_size_i;
    end
  end

  assign valid_o     = valid_q;
  assign ld_match_o  = valid_q && (reg_q == wr_reg_i);
  assign chk_match_o = valid_q && (reg_q == chk_reg_i);

  // R9
  clear_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !valid_q);

  // R4
  store_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && kill_old && !wr_i) |=> !valid_q);

  // R3
  insert_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clear_i && !st_valid_i) |=> valid_q);

endmodule

// File: rtl/spec_ld_alloc.sv
module spec_ld_alloc #(
  parameter int ENTRIES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] reg_hit_i,
  output logic [ENTRIES-1:0] wr_o
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   rr_q;
  logic [ENTRIES-1:0] free_oh, victim_oh;
  logic               free_any, use_victim;

  always_comb begin
    free_oh  = '0;
    free_any = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !free_any) begin
        free_oh[i] = 1'b1;
        free_any   = 1'b1;
      end
    end
  end

  always_comb begin
    victim_oh       = '0;
    victim_oh[rr_q] = 1'b1;
  end

  assign use_victim = req_i && !(|reg_hit_i) && !free_any;

  always_comb begin
    if (!req_i)          wr_o = '0;
    else if (|reg_hit_i) wr_o = reg_hit_i;
    else if (free_any)   wr_o = free_oh;
    else                 wr_o = victim_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rr_q <= '0;
    else if (use_victim) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  // R5
  uniq_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_hit_i));

  // R6
  one_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o));

  // R7
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_victim && rr_q != LAST) |=> rr_q == $past(rr_q) + 1'b1);

  // R7
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_victim |=> $stable(rr_q));

endmodule

// File: rtl/spec_ld_tbl.sv
module spec_ld_tbl
  import spec_ld_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 48,
  parameter int REG_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              ld_valid_i,
  input  logic [REG_W-1:0]  ld_reg_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [1:0]        ld_size_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [1:0]        st_size_i,
  input  logic              chk_valid_i,
  input  logic [REG_W-1:0]  chk_reg_i,
  output logic              chk_done_o,
  output logic              chk_hit_o
);

  logic [ENTRIES-1:0] valid_v, ld_hit_v, chk_hit_v, wr_v;
  logic               chk_done_q, chk_hit_q;

  spec_ld_alloc #(.ENTRIES(ENTRIES)) alloc_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (ld_valid_i && !clear_i),
    .valid_i   (valid_v),
    .reg_hit_i (ld_hit_v),
    .wr_o      (wr_v)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    spec_ld_entry #(.ADDR_W(ADDR_W), .REG_W(REG_W)) ent_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (clear_i),
      .wr_i        (wr_v[g]),
      .wr_reg_i    (ld_reg_i),
      .wr_addr_i   (ld_addr_i),
      .wr_size_i   (sz_e'(ld_size_i)),
      .st_valid_i  (st_valid_i),
      .st_addr_i   (st_addr_i),
      .st_size_i   (sz_e'(st_size_i)),
      .chk_reg_i   (chk_reg_i),
      .valid_o     (valid_v[g]),
      .ld_match_o  (ld_hit_v[g]),
      .chk_match_o (chk_hit_v[g])
    );
  end

  // response uses pre-update state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_done_q <= 1'b0;
      chk_hit_q  <= 1'b0;
    end else begin
      chk_done_q <= chk_valid_i;
      chk_hit_q  <= chk_valid_i && (|chk_hit_v);
    end
  end

  assign chk_done_o = chk_done_q;
  assign chk_hit_o  = chk_hit_q;

  // R2
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i |=> chk_done_o);

  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_i |=> !chk_done_o);

  // R2
  hit_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_done_o |-> !chk_hit_o);

endmodule

// File: tb/spec_ld_tbl_tb.sv
module spec_ld_tbl_tb_top;

  localparam int ENTRIES = 32;
  localparam int ADDR_W  = 48;
  localparam int REG_W   = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clear = 1'b0;
  logic              ld_valid = 1'b0;
  logic [REG_W-1:0]  ld_reg = '0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [1:0]        ld_size = '0;
  logic              st_valid = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [1:0]        st_size = '0;
  logic              chk_valid = 1'b0;
  logic [REG_W-1:0]  chk_reg = '0;
  logic              chk_done, chk_hit;

  always #2 clk = ~clk;

  spec_ld_tbl #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .REG_W(REG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .ld_valid_i(ld_valid), .ld_reg_i(ld_reg), .ld_addr_i(ld_addr), .ld_size_i(ld_size),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_size_i(st_size),
    .chk_valid_i(chk_valid), .chk_reg_i(chk_reg),
    .chk_done_o(chk_done), .chk_hit_o(chk_hit)
  );

  typedef struct {
    bit    hit;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   fin = 1'b0;

  task automatic expect_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    ld_valid  = 1'b0;
    st_valid  = 1'b0;
    chk_valid = 1'b0;
    clear     = 1'b0;
  endtask

  task automatic set_ins(int r, longint a, int s);
    ld_valid = 1'b1;
    ld_reg   = REG_W'(r);
    ld_addr  = ADDR_W'(a);
    ld_size  = 2'(s);
  endtask

  task automatic set_st(longint a, int s);
    st_valid = 1'b1;
    st_addr  = ADDR_W'(a);
    st_size  = 2'(s);
  endtask

  task automatic set_chk(int r, bit exp, string tag);
    exp_t e;
    chk_valid = 1'b1;
    chk_reg   = REG_W'(r);
    e.hit = exp;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic ins(int r, longint a, int s);
    set_ins(r, a, s);
    tick();
  endtask

  task automatic st(longint a, int s);
    set_st(a, s);
    tick();
  endtask

  task automatic chk(int r, bit exp, string tag);
    set_chk(r, exp, tag);
    tick();
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && chk_done) begin
      exp_t e;
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected response act=1 exp=0");
      end else begin
        e = sb_q.pop_front();
        if (chk_hit !== e.hit) begin
          n_fail++;
          $display("FAIL %s hit act=%0d exp=%0d", e.tag, chk_hit, e.hit);
        end
      end
    end
  end

  initial begin
    repeat (6000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_eq("R1 done after reset", int'(chk_done), 0);
    chk(3, 1'b0, "R1 empty table");

    // R3 insert then check; R2 other register misses
    ins(3, 'h100, 3);
    chk(3, 1'b1, "R3 inserted hit");
    chk(4, 1'b0, "R2 absent register");

    // R4 overlap forms
    st('h104, 0);
    chk(3, 1'b0, "R4 inner byte store");
    ins(3, 'h100, 3);
    st('h108, 3);
    chk(3, 1'b1, "R4 adjacent above");
    st('h0FC, 2);
    chk(3, 1'b1, "R4 adjacent below");
    st('h0FE, 2);
    chk(3, 1'b0, "R4 straddle low edge");
    ins(10, 'h200, 2);
    ins(11, 'h204, 2);
    ins(12, 'h300, 2);
    st('h200, 3);
    chk(10, 1'b0, "R4 multi kill a");
    chk(11, 1'b0, "R4 multi kill b");
    chk(12, 1'b1, "R4 untouched");

    // R5 overwrite same register
    ins(12, 'h400, 2);
    st('h300, 2);
    chk(12, 1'b1, "R5 old range ignored");
    st('h403, 0);
    chk(12, 1'b0, "R5 new range kills");

    // R10 check sees pre-update state
    set_ins(20, 'h500, 2); set_chk(20, 1'b0, "R10 check with insert"); tick();
    chk(20, 1'b1, "R10 after insert");
    set_st('h500, 0); set_chk(20, 1'b1, "R10 check with store"); tick();
    chk(20, 1'b0, "R10 after store");

    // R8 same-cycle insert and store
    set_ins(21, 'h600, 2); set_st('h602, 0); tick();
    chk(21, 1'b0, "R8 overlapping store wins");
    set_ins(22, 'h700, 2); set_st('h704, 2); tick();
    chk(22, 1'b1, "R8 disjoint store");

    // R9 clear, and R10 check beside clear
    clear = 1'b1; set_chk(22, 1'b1, "R10 check with clear"); tick();
    chk(22, 1'b0, "R9 cleared");
    clear = 1'b1; set_ins(23, 'h800, 2); tick();
    chk(23, 1'b0, "R9 insert dropped");

    // R6 fill all entries
    for (int i = 0; i < ENTRIES; i++) ins(i, 'h1000 + 16 * i, 3);
    for (int i = 0; i < ENTRIES; i++) chk(i, 1'b1, "R6 full occupancy");

    // R6 freed slot reused before any victim
    st('h1050, 0);
    chk(5, 1'b0, "R6 slot freed");
    ins(50, 'h2000, 2);
    chk(50, 1'b1, "R6 free slot used");
    chk(0, 1'b1, "R6 no victim taken");
    chk(31, 1'b1, "R6 no victim taken");

    // R7 round robin from entry 0
    ins(60, 'h3000, 2);
    chk(0, 1'b0, "R7 first victim entry 0");
    chk(1, 1'b1, "R7 entry 1 kept");
    chk(60, 1'b1, "R7 new entry live");
    ins(61, 'h3100, 2);
    chk(1, 1'b0, "R7 second victim entry 1");
    chk(2, 1'b1, "R7 entry 2 kept");

    // R5 overwrite while full does not move the pointer
    ins(10, 'h4000, 2);
    chk(2, 1'b1, "R5 overwrite took no victim");
    chk(10, 1'b1, "R5 overwritten live");
    ins(62, 'h3200, 2);
    chk(2, 1'b0, "R7 third victim entry 2");
    chk(3, 1'b1, "R7 entry 3 kept");

    repeat (3) tick();
    expect_eq("R2 all responses seen", sb_q.size(), 0);
    expect_eq("R2 done idle", int'(chk_done), 0);

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule